// File: doc/BRIEF.md
# Replication-Aware Victim Selector with N-Chance Spilling

This block makes the replacement decision for one private L2 slice in a group of slices that cooperate with each other. On a fill request it looks at the state of every way in the target set and chooses the way to overwrite. Each resident block is either a replica, meaning another slice also holds a copy, or a singlet, meaning this slice holds the only on-chip copy. Replicas are evicted before singlets, because losing a replica costs nothing beyond this slice. An empty way is always used first.

When a singlet has to go, the block can forward it to a peer slice instead of discarding it. Each block carries a history bit that records whether it arrived by spilling, and a recirculation count. A singlet spilled for the first time leaves with the count set to the parameter N. A block that arrived by spilling leaves with its count reduced by one. A block whose count is already zero is dropped. The caller also gives a flag on the fill request that says whether the incoming block is itself a spilled arrival. The block returns that flag as the history bit to store with the new block.

The decision is registered one cycle after the request is accepted. It stays on the outputs until the caller acknowledges it. A new request is accepted when no result is pending, or in the same cycle that the pending result is acknowledged.

Top module: `repl_spill_ctrl`

## Requirements
- R1: While reset is high, and in the cycle after it is released, rsp_valid is 0.
- R2: A request with req_valid=1 is accepted when no result is pending. In the next cycle rsp_valid=1 and rsp_set equals the accepted req_set. A request made while a result is pending and not acknowledged is ignored: the held outputs do not change.
- R3: If any way has way_valid=0, the result is the lowest-indexed invalid way.
- R4: If all ways are valid and at least one has way_replica=1, the result is a replica way. It is the way with the largest age among the replicas, and the lowest index wins a tie. Way i's age is way_age[i*AGE_W +: AGE_W], and a larger value means older.
- R5: If all ways are valid and none is a replica, the result is the oldest valid way, with the lowest index winning a tie.
- R6: A replica victim gives rsp_evict=1, rsp_drop=1 and rsp_spill=0.
- R7: A singlet victim with way_hist=0 gives rsp_spill=1 with rsp_spill_cnt=N.
- R8: A singlet victim with way_hist=1 and count c>0 gives rsp_spill=1 with rsp_spill_cnt=c-1. Way i's count is way_cnt[i*CNT_W +: CNT_W].
- R9: A singlet victim with way_hist=1 and count 0 gives rsp_drop=1 and rsp_spill=0.
- R10: An invalid victim way gives rsp_evict=0, rsp_spill=0 and rsp_drop=0.
- R11: rsp_fill_hist equals the fill_from_spill value of the accepted request.
- R12: While rsp_valid=1 and rsp_ack=0, all result outputs hold their values. An rsp_ack together with a new req_valid replaces the result in the next cycle. An rsp_ack alone clears rsp_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Fill request needs a victim |
| req_set | input | SET_W | Target set index |
| fill_from_spill | input | 1 | Incoming block arrived by spilling |
| way_valid | input | WAYS | Per-way valid |
| way_age | input | WAYS*AGE_W | Per-way LRU age, larger is older |
| way_replica | input | WAYS | Per-way replica flag (1 = copy exists elsewhere) |
| way_hist | input | WAYS | Per-way spilled-arrival history bit |
| way_cnt | input | WAYS*CNT_W | Per-way recirculation count |
| rsp_ack | input | 1 | Caller consumes the held result |
| rsp_valid | output | 1 | Result pending |
| rsp_set | output | SET_W | Set of the result |
| rsp_way | output | WAY_W | Chosen victim way |
| rsp_evict | output | 1 | Victim way held a valid block |
| rsp_spill | output | 1 | Forward victim to a peer slice |
| rsp_drop | output | 1 | Discard victim |
| rsp_spill_cnt | output | CNT_W | Count to travel with the spilled block |
| rsp_fill_hist | output | 1 | History bit to store with the new block |

## Verification
Two things can happen in the same cycle: an acknowledge of the held result and the acceptance of a new request. Random traffic drives req_valid and rsp_ack on their own, so this overlap occurs often. It also occurs next to cycles with an acknowledge but no request, and cycles with a request but no acknowledge. A reference model in the bench tracks the pending result. It expects the new decision to replace the old one right away when both arrive together, and expects an ignored request to leave every held field unchanged. The per-way state is randomised so that each class is reached many times: empty ways, replica-first choices, age ties, and each spill and drop outcome.

// File: rtl/rss_pkg.sv
package rss_pkg;
  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_SPILL = 2'd1,
    ACT_DROP  = 2'd2
  } vic_act_e;
endpackage

// File: rtl/rss_victim_pick.sv
module rss_victim_pick #(
  parameter int WAYS  = 4,
  parameter int AGE_W = 2,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]       valid,
  input  logic [WAYS-1:0]       replica,
  input  logic [WAYS*AGE_W-1:0] age,
  output logic [WAY_W-1:0]      way,
  output logic                  way_occupied
);
  logic             any_free;
  logic [WAY_W-1:0] free_way;
  logic             any_rep;
  logic [WAYS-1:0]  cand;
  logic [WAY_W-1:0] best_way;
  logic [AGE_W-1:0] best_age;
  logic             found;

  assign any_rep = |(valid & replica);
  assign cand    = any_rep ? (valid & replica) : valid;

  always_comb begin
    any_free = 1'b0;
    free_way = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        any_free = 1'b1;
        free_way = WAY_W'(i);
      end
    end
  end

  always_comb begin
    found    = 1'b0;
    best_way = '0;
    best_age = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (cand[i] && (!found || age[i*AGE_W +: AGE_W] > best_age)) begin
        found    = 1'b1;
        best_way = WAY_W'(i);
        best_age = age[i*AGE_W +: AGE_W];
      end
    end
  end

  assign way          = any_free ? free_way : best_way;
  assign way_occupied = !any_free;
endmodule

// File: rtl/rss_spill_decide.sv
module rss_spill_decide
  import rss_pkg::*;
#(
  parameter int N_CHANCE = 1,
  localparam int CNT_W = (N_CHANCE < 1) ? 1 : $clog2(N_CHANCE + 1)
) (
  input  logic             occupied,
  input  logic             is_replica,
  input  logic             has_hist,
  input  logic [CNT_W-1:0] cnt_in,
  output vic_act_e         act,
  output logic [CNT_W-1:0] cnt_out
);
  always_comb begin
    act     = ACT_NONE;
    cnt_out = '0;
    if (occupied) begin
      if (is_replica) begin
        act = ACT_DROP;
      end else if (!has_hist) begin
        act     = ACT_SPILL;
        cnt_out = CNT_W'(N_CHANCE);
      end else if (cnt_in != '0) begin
        act     = ACT_SPILL;
        cnt_out = cnt_in - CNT_W'(1);
      end else begin
        act = ACT_DROP;
      end
    end
  end
endmodule

// File: rtl/repl_spill_ctrl.sv
module repl_spill_ctrl
  import rss_pkg::*;
#(
  parameter int WAYS     = 4,
  parameter int SET_W    = 6,
  parameter int AGE_W    = 2,
  parameter int N_CHANCE = 1,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int CNT_W = (N_CHANCE < 1) ? 1 : $clog2(N_CHANCE + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic [SET_W-1:0]       req_set,
  input  logic                   fill_from_spill,
  input  logic [WAYS-1:0]        way_valid,
  input  logic [WAYS*AGE_W-1:0]  way_age,
  input  logic [WAYS-1:0]        way_replica,
  input  logic [WAYS-1:0]        way_hist,
  input  logic [WAYS*CNT_W-1:0]  way_cnt,
  input  logic                   rsp_ack,
  output logic                   rsp_valid,
  output logic [SET_W-1:0]       rsp_set,
  output logic [WAY_W-1:0]       rsp_way,
  output logic                   rsp_evict,
  output logic                   rsp_spill,
  output logic                   rsp_drop,
  output logic [CNT_W-1:0]       rsp_spill_cnt,
  output logic                   rsp_fill_hist
);
  logic [WAY_W-1:0] vic_way;
  logic             vic_occ;
  vic_act_e         vic_act;
  logic [CNT_W-1:0] vic_new_cnt;
  logic             accept;

  rss_victim_pick #(.WAYS(WAYS), .AGE_W(AGE_W)) pick_i (
    .valid        (way_valid),
    .replica      (way_replica),
    .age          (way_age),
    .way          (vic_way),
    .way_occupied (vic_occ)
  );

  rss_spill_decide #(.N_CHANCE(N_CHANCE)) decide_i (
    .occupied   (vic_occ),
    .is_replica (way_replica[vic_way]),
    .has_hist   (way_hist[vic_way]),
    .cnt_in     (way_cnt[vic_way*CNT_W +: CNT_W]),
    .act        (vic_act),
    .cnt_out    (vic_new_cnt)
  );

  assign accept = req_valid && (!rsp_valid || rsp_ack);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid     <= 1'b0;
      rsp_set       <= '0;
      rsp_way       <= '0;
      rsp_evict     <= 1'b0;
      rsp_spill     <= 1'b0;
      rsp_drop      <= 1'b0;
      rsp_spill_cnt <= '0;
      rsp_fill_hist <= 1'b0;
    end else if (accept) begin
      rsp_valid     <= 1'b1;
      rsp_set       <= req_set;
      rsp_way       <= vic_way;
      rsp_evict     <= vic_occ;
      rsp_spill     <= (vic_act == ACT_SPILL);
      rsp_drop      <= (vic_act == ACT_DROP);
      rsp_spill_cnt <= vic_new_cnt;
      rsp_fill_hist <= fill_from_spill;
    end else if (rsp_ack) begin
      rsp_valid <= 1'b0;
    end
  end

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && !rsp_valid |=> rsp_valid);

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ack |=> rsp_valid && $stable(rsp_way) && $stable(rsp_set)
      && $stable(rsp_spill) && $stable(rsp_drop));

  // R9
  spill_drop_excl_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !(rsp_spill && rsp_drop));

  // R10
  evict_needed_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && (rsp_spill || rsp_drop) |-> rsp_evict);

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_spill |-> rsp_spill_cnt <= CNT_W'(N_CHANCE));

  // R12
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_ack && !req_valid |=> !rsp_valid);
endmodule

// File: tb/repl_spill_ctrl_tb.sv
`timescale 1ns/1ps
module repl_spill_ctrl_tb_top;
  localparam int WAYS = 4, SET_W = 6, AGE_W = 2, NCH = 1, WAY_W = 2, CNT_W = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [SET_W-1:0] req_set = '0;
  logic fill_from_spill = 1'b0;
  logic [WAYS-1:0] way_valid = '0, way_replica = '0, way_hist = '0;
  logic [WAYS*AGE_W-1:0] way_age = '0;
  logic [WAYS*CNT_W-1:0] way_cnt = '0;
  logic rsp_ack = 1'b0;
  logic rsp_valid, rsp_evict, rsp_spill, rsp_drop, rsp_fill_hist;
  logic [SET_W-1:0] rsp_set;
  logic [WAY_W-1:0] rsp_way;
  logic [CNT_W-1:0] rsp_spill_cnt;

  always #2.5 clk = ~clk;

  repl_spill_ctrl #(.WAYS(WAYS), .SET_W(SET_W), .AGE_W(AGE_W), .N_CHANCE(NCH)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_set(req_set),
    .fill_from_spill(fill_from_spill), .way_valid(way_valid), .way_age(way_age),
    .way_replica(way_replica), .way_hist(way_hist), .way_cnt(way_cnt),
    .rsp_ack(rsp_ack), .rsp_valid(rsp_valid), .rsp_set(rsp_set), .rsp_way(rsp_way),
    .rsp_evict(rsp_evict), .rsp_spill(rsp_spill), .rsp_drop(rsp_drop),
    .rsp_spill_cnt(rsp_spill_cnt), .rsp_fill_hist(rsp_fill_hist));

  int n_cmp = 0, n_bad = 0;
  bit e_valid = 0, e_evict = 0, e_spill = 0, e_drop = 0, e_hist = 0;
  int e_set = 0, e_way = 0, e_cnt = 0;
  string e_wtag = "R3", e_atag = "R10";

  // behavioural model of the decision
  always @(posedge clk) begin
    if (rst) begin
      e_valid = 0;
    end else if (req_valid && (!e_valid || rsp_ack)) begin
      int oldest, w, a;
      bit rep_seen;
      w = -1;
      for (int i = 0; i < WAYS; i++) if (w < 0 && !way_valid[i]) w = i;
      if (w >= 0) begin
        e_wtag = "R3"; e_atag = "R10";
        e_evict = 0; e_spill = 0; e_drop = 0; e_cnt = 0;
      end else begin
        rep_seen = 0;
        for (int i = 0; i < WAYS; i++) if (way_replica[i]) rep_seen = 1;
        e_wtag = rep_seen ? "R4" : "R5";
        oldest = -1;
        for (int i = 0; i < WAYS; i++)
          if (!rep_seen || way_replica[i]) begin
            a = int'(way_age[i*AGE_W +: AGE_W]);
            if (a > oldest) oldest = a;
          end
        for (int i = WAYS - 1; i >= 0; i--)
          if ((!rep_seen || way_replica[i]) && int'(way_age[i*AGE_W +: AGE_W]) == oldest) w = i;
        e_evict = 1; e_cnt = 0;
        if (way_replica[w]) begin
          e_atag = "R6"; e_spill = 0; e_drop = 1;
        end else if (!way_hist[w]) begin
          e_atag = "R7"; e_spill = 1; e_drop = 0; e_cnt = NCH;
        end else if (way_cnt[w*CNT_W +: CNT_W] != 0) begin
          e_atag = "R8"; e_spill = 1; e_drop = 0; e_cnt = int'(way_cnt[w*CNT_W +: CNT_W]) - 1;
        end else begin
          e_atag = "R9"; e_spill = 0; e_drop = 1;
        end
      end
      e_valid = 1; e_way = w; e_set = int'(req_set); e_hist = fill_from_spill;
    end else if (rsp_ack) begin
      e_valid = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(rsp_valid == e_valid, rst ? "R1" : "R2/R12", "rsp_valid", int'(rsp_valid), int'(e_valid));
    if (e_valid && rsp_valid) begin
      chk(int'(rsp_set) == e_set, "R2", "rsp_set", int'(rsp_set), e_set);
      chk(int'(rsp_way) == e_way, e_wtag, "rsp_way", int'(rsp_way), e_way);
      chk(rsp_evict == e_evict, e_atag, "rsp_evict", int'(rsp_evict), int'(e_evict));
      chk(rsp_spill == e_spill, e_atag, "rsp_spill", int'(rsp_spill), int'(e_spill));
      chk(rsp_drop == e_drop, e_atag, "rsp_drop", int'(rsp_drop), int'(e_drop));
      if (e_spill) chk(int'(rsp_spill_cnt) == e_cnt, e_atag, "rsp_spill_cnt", int'(rsp_spill_cnt), e_cnt);
      chk(rsp_fill_hist == e_hist, "R11", "rsp_fill_hist", int'(rsp_fill_hist), int'(e_hist));
    end
  endtask

  bit finished = 0;

  initial begin
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      compare();  // R1 during reset
    end
    rst = 1'b0;
    @(negedge clk);
    compare();    // R1 first cycle after release
    for (int c = 0; c < 6000; c++) begin
      req_valid       = ($urandom_range(0, 9) < 7);
      rsp_ack         = ($urandom_range(0, 9) < 6);
      req_set         = SET_W'($urandom);
      fill_from_spill = 1'($urandom);
      for (int i = 0; i < WAYS; i++) begin
        way_valid[i]   = ($urandom_range(0, 19) < 17);
        way_replica[i] = ($urandom_range(0, 9) < 3);
        way_hist[i]    = 1'($urandom);
        way_cnt[i*CNT_W +: CNT_W] = CNT_W'($urandom_range(0, NCH));
        way_age[i*AGE_W +: AGE_W] = AGE_W'($urandom);
      end
      @(negedge clk);
      compare();
    end
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule